// File: doc/BRIEF.md
# Key-Guarded Configuration Register

This block keeps one configuration word, such as a pin-function selection, out of reach of stray or runaway bus writes. The host reaches it over a plain synchronous write bus: an address, a data word and a one-cycle write strobe. A new value becomes live only when three bus writes arrive back to back. The first is an unlock key on its own address. The second is the new value on the configuration address. The third is a confirm key on a third address. The value from the middle write waits in a shadow register and is copied to the live register only when the confirm write arrives.

The block counts only write strobes. Cycles with the strobe low may sit anywhere in the sequence. Any other write during the sequence aborts it and throws away the shadow value, and so does a key with the wrong value. Either case raises a violation flag that stays high until reset. Software that drives the bus wraps its configuration update in the two key writes. A monitor can watch the violation flag to detect bus traffic that breaks the protocol. The same flow fits a word in which bit 1, for example, switches two pins over to a serial-bus function.

Top module: `keyed_cfg_guard`

## Requirements
- R1: After reset `cfgValue` is 0, `violation` is 0 and no sequence is in progress, so a configuration write followed by a confirm write right after reset changes nothing.
- R2: A write of 0x0007 to address 1 (unlock), then a write of data D to address 2 (configuration), then a write of 0x0013 to address 3 (confirm), with no other write between them, makes `cfgValue` equal D in the cycle after the clock edge that takes the confirm write.
- R3: The configuration write alone does not change `cfgValue`, and the old value stays visible until the confirm write.
- R4: A configuration write or confirm write not preceded by a correct unlock write is ignored: `cfgValue` is unchanged and `violation` stays 0.
- R5: A write to the unlock address with a value other than 0x0007 sets `violation`, and a configuration write followed by a confirm write after it does not commit.
- R6: Any write other than to the configuration address, made right after a correct unlock write, aborts the sequence and sets `violation`, and the configuration and confirm writes that follow do not commit.
- R7: Any write made right after the configuration write, other than 0x0013 to the confirm address, discards the shadow value and sets `violation`, and a later correct confirm write does not commit.
- R8: Cycles with `wrEn` low between the three writes do not break the sequence.
- R9: `violation` is sticky until reset, and a later valid three-write sequence still commits.
- R10: `cfgValue` changes only on the clock edge that follows a correct confirm write, and writes to other addresses (0, 4 to 15) never change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one write per cycle it is high |
| wrAddr | input | 4 | Write address |
| wrData | input | 16 | Write data |
| cfgValue | output | 16 | Committed configuration value |
| violation | output | 1 | Sticky protocol-violation flag |

## Verification
The hardest state to reach from the ports is a pending shadow value that is cancelled by the write that follows it. That write may go to a foreign address or may carry an almost-correct confirm key. In either case the live value must survive, and a later confirm write alone must find nothing to commit. The bench reaches that state with a correct unlock and configuration write, then inserts the wrong write, then sends a correct confirm write. It checks `cfgValue` and `violation` after each step, with reset applied between scenarios because the flag is sticky.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_ARMED   = 2'd1,
    SEQ_PENDING = 2'd2
  } seqState_t;

  typedef struct packed {
    logic loadShadow;
    logic commit;
    logic discard;
    logic setViol;
  } guardStrobe_t;

endpackage

// File: rtl/keyed_cfg_ctrl.sv
module keyed_cfg_ctrl
  import keyed_cfg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR  = 1,
  parameter logic [ADDR_W-1:0] CFG_ADDR     = 2,
  parameter logic [ADDR_W-1:0] CONFIRM_ADDR = 3,
  parameter logic [DATA_W-1:0] UNLOCK_KEY   = 7,
  parameter logic [DATA_W-1:0] CONFIRM_KEY  = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output guardStrobe_t      strobe
);

  seqState_t state, stateNxt;
  logic hitUnlock, hitCfg, hitConfirm;
  logic unlockOk, confirmOk;

  assign hitUnlock  = (wrAddr == UNLOCK_ADDR);
  assign hitCfg     = (wrAddr == CFG_ADDR);
  assign hitConfirm = (wrAddr == CONFIRM_ADDR);
  assign unlockOk   = hitUnlock && (wrData == UNLOCK_KEY);
  assign confirmOk  = hitConfirm && (wrData == CONFIRM_KEY);

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    if (wrEn) begin
      unique case (state)
        SEQ_IDLE: begin
          if (unlockOk)       stateNxt = SEQ_ARMED;
          else if (hitUnlock) strobe.setViol = 1'b1;
        end
        SEQ_ARMED: begin
          if (hitCfg) begin
            strobe.loadShadow = 1'b1;
            stateNxt          = SEQ_PENDING;
          end else begin
            strobe.setViol = 1'b1;
            stateNxt       = SEQ_IDLE;
          end
        end
        SEQ_PENDING: begin
          stateNxt = SEQ_IDLE;
          if (confirmOk) begin
            strobe.commit = 1'b1;
          end else begin
            strobe.discard = 1'b1;
            strobe.setViol = 1'b1;
          end
        end
        default: stateNxt = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNxt;
  end

endmodule

// File: rtl/keyed_cfg_datapath.sv
module keyed_cfg_datapath
  import keyed_cfg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  guardStrobe_t      strobe,
  output logic [DATA_W-1:0] cfgValue,
  output logic              violation
);

  logic [DATA_W-1:0] shadowReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowReg <= '0;
    end else if (strobe.loadShadow) begin
      shadowReg <= wrData;
    end else if (strobe.commit || strobe.discard) begin
      shadowReg <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cfgValue <= '0;
    else if (strobe.commit) cfgValue <= shadowReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               violation <= 1'b0;
    else if (strobe.setViol) violation <= 1'b1;
  end

endmodule

// File: rtl/keyed_cfg_guard.sv
module keyed_cfg_guard
  import keyed_cfg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR  = 1,
  parameter logic [ADDR_W-1:0] CFG_ADDR     = 2,
  parameter logic [ADDR_W-1:0] CONFIRM_ADDR = 3,
  parameter logic [DATA_W-1:0] UNLOCK_KEY   = 7,
  parameter logic [DATA_W-1:0] CONFIRM_KEY  = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] cfgValue,
  output logic              violation
);

  guardStrobe_t strobe;

  keyed_cfg_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .UNLOCK_ADDR(UNLOCK_ADDR), .CFG_ADDR(CFG_ADDR), .CONFIRM_ADDR(CONFIRM_ADDR),
    .UNLOCK_KEY(UNLOCK_KEY), .CONFIRM_KEY(CONFIRM_KEY)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe)
  );

  keyed_cfg_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strobe(strobe),
    .cfgValue(cfgValue), .violation(violation)
  );

endmodule

// File: rtl/keyed_cfg_guard_chk.sv
module keyed_cfg_guard_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] CONFIRM_ADDR = 3,
  parameter logic [DATA_W-1:0] CONFIRM_KEY  = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] cfgValue,
  input logic              violation
);

  // R10
  cfg_change_needs_confirm_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgValue) |-> $past(wrEn && wrAddr == CONFIRM_ADDR && wrData == CONFIRM_KEY));

  // R8
  idle_cycle_holds_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(cfgValue));

  // R9
  violation_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> violation);

  // R5
  violation_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(violation) |-> $past(wrEn));

endmodule

bind keyed_cfg_guard keyed_cfg_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CONFIRM_ADDR(CONFIRM_ADDR), .CONFIRM_KEY(CONFIRM_KEY)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .cfgValue(cfgValue), .violation(violation)
);

// File: tb/keyed_cfg_guard_tb_top.sv
module keyed_cfg_guard_tb_top;

  localparam logic [3:0]  A_UNLOCK  = 4'd1;
  localparam logic [3:0]  A_CFG     = 4'd2;
  localparam logic [3:0]  A_CONFIRM = 4'd3;
  localparam logic [15:0] K_UNLOCK  = 16'h0007;
  localparam logic [15:0] K_CONFIRM = 16'h0013;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] cfgValue;
  logic        violation;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  keyed_cfg_guard dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cfgValue(cfgValue), .violation(violation)
  );

  task automatic checkVal(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic t_reset();
    doReset();
    checkVal("R1 cfg after reset", cfgValue, 16'h0);
    checkVal("R1 viol after reset", {15'b0, violation}, 16'h0);
    busWrite(A_CFG, 16'h00FF);
    busWrite(A_CONFIRM, K_CONFIRM);
    checkVal("R1 no pending after reset", cfgValue, 16'h0);
  endtask

  task automatic t_commit();
    doReset();
    busWrite(A_UNLOCK, K_UNLOCK);
    busWrite(A_CFG, 16'h1002);
    checkVal("R3 cfg before confirm", cfgValue, 16'h0);
    busWrite(A_CONFIRM, K_CONFIRM);
    checkVal("R2 cfg committed", cfgValue, 16'h1002);
    checkVal("R2 no violation", {15'b0, violation}, 16'h0);
    busWrite(A_UNLOCK, K_UNLOCK);
    repeat (3) @(negedge clk);
    busWrite(A_CFG, 16'hABCD);
    repeat (2) @(negedge clk);
    checkVal("R3 old value held", cfgValue, 16'h1002);
    busWrite(A_CONFIRM, K_CONFIRM);
    checkVal("R8 commit across idle cycles", cfgValue, 16'hABCD);
  endtask

  task automatic t_noUnlock();
    doReset();
    busWrite(A_CFG, 16'h0002);
    busWrite(A_CONFIRM, K_CONFIRM);
    checkVal("R4 unarmed cfg ignored", cfgValue, 16'h0);
    checkVal("R4 no violation", {15'b0, violation}, 16'h0);
    for (int a = 4; a < 16; a++) busWrite(a[3:0], 16'hFFFF);
    busWrite(4'd0, 16'hFFFF);
    checkVal("R10 foreign writes leave cfg", cfgValue, 16'h0);
  endtask

  task automatic t_badUnlock();
    doReset();
    busWrite(A_UNLOCK, 16'h0008);
    checkVal("R5 viol on bad unlock", {15'b0, violation}, 16'h1);
    busWrite(A_CFG, 16'h0002);
    busWrite(A_CONFIRM, K_CONFIRM);
    checkVal("R5 no commit", cfgValue, 16'h0);
  endtask

  task automatic t_breakArmed();
    doReset();
    busWrite(A_UNLOCK, K_UNLOCK);
    busWrite(4'd5, 16'h0002);
    checkVal("R6 viol on foreign write", {15'b0, violation}, 16'h1);
    busWrite(A_CFG, 16'h0002);
    busWrite(A_CONFIRM, K_CONFIRM);
    checkVal("R6 no commit after abort", cfgValue, 16'h0);
  endtask

  task automatic t_breakPending();
    doReset();
    busWrite(A_UNLOCK, K_UNLOCK);
    busWrite(A_CFG, 16'h0042);
    busWrite(4'd0, 16'h0000);
    checkVal("R7 viol on foreign write", {15'b0, violation}, 16'h1);
    busWrite(A_CONFIRM, K_CONFIRM);
    checkVal("R7 shadow discarded", cfgValue, 16'h0);
    doReset();
    busWrite(A_UNLOCK, K_UNLOCK);
    busWrite(A_CFG, 16'h0042);
    busWrite(A_CONFIRM, 16'h0012);
    checkVal("R7 viol on bad confirm", {15'b0, violation}, 16'h1);
    checkVal("R7 no commit on bad confirm", cfgValue, 16'h0);
    busWrite(A_CONFIRM, K_CONFIRM);
    checkVal("R7 late confirm no commit", cfgValue, 16'h0);
  endtask

  task automatic t_sticky();
    doReset();
    busWrite(A_UNLOCK, 16'h0000);
    busWrite(A_UNLOCK, K_UNLOCK);
    busWrite(A_CFG, 16'h5A5A);
    busWrite(A_CONFIRM, K_CONFIRM);
    checkVal("R9 commit despite flag", cfgValue, 16'h5A5A);
    repeat (4) @(negedge clk);
    checkVal("R9 flag sticky", {15'b0, violation}, 16'h1);
    doReset();
    checkVal("R9 reset clears flag", {15'b0, violation}, 16'h0);
  endtask

  initial begin
    t_reset();
    t_commit();
    t_noUnlock();
    t_badUnlock();
    t_breakArmed();
    t_breakPending();
    t_sticky();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule